// File: doc/BRIEF.md
# Receive Queue with Per-Character Error Tags

This block sits between a serial receiver and a host. The receiver hands over each finished character as a single-cycle strobe, together with a data byte and three error flags: break, framing and parity. In queued mode the block keeps up to `DEPTH` characters with their flags, plus one extra holding slot that stands for the receiver's shift register. In single mode it acts as a one-character holding register.

The host reads the oldest byte through `rdData` and removes it with `dataRd`. It sees status on a set of line-status outputs and acknowledges them with `lsrRd`. The error flags apply only to the character now at the head of the queue. An overrun is reported at once, in the cycle after it happens. A programmable threshold raises `rdAvail` when enough characters are waiting.

Top module: `rx_err_queue`

## Requirements
- R1: Characters leave in arrival order. While the queue is not empty, `rdData` shows the oldest byte. A `dataRd` pulse removes that byte, and the next byte appears after the following clock edge.
- R2: `breakErr`, `framingErr` and `parityErr` show only the flags stored with the head character. A flag on a later character appears only after every character ahead of it has been read.
- R3: The edge after an `lsrRd` pulse clears `overrun` and hides the head flags. The head flags stay hidden until the head character changes.
- R4: With `fifoEn` low, a character that arrives while the previous one is still unread sets `overrun`. The new byte and its flags replace the old one, which is lost.
- R5: With `fifoEn` high, a character that arrives while the queue holds `DEPTH` entries goes to the holding slot and does not set `overrun`. The first read after that moves the held character into the queue.
- R6: With `fifoEn` high, a character that arrives while the queue is full and the holding slot is occupied sets `overrun` on the next edge. It replaces the held character, and the replaced character is never delivered.
- R7: `dataReady` is high exactly while at least one character is queued. It is low after reset and after the last character is read.
- R8: With `fifoEn` high, `rdAvail` is high when the queued count is at least the threshold that `trigSel` selects: 0 selects 1, 1 selects 4, 2 selects 8, 3 selects 14 (for `DEPTH` of 16). With `fifoEn` low, `rdAvail` follows `dataReady`.
- R9: A `fifoClr` pulse empties the queue and the holding slot. It leaves `overrun` unchanged.
- R10: A `dataRd` pulse while the queue is empty has no effect. The count stays zero, and the next character is delivered intact.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| fifoEn | input | 1 | 1 = queued mode, 0 = single holding register |
| trigSel | input | 2 | Threshold select for rdAvail |
| fifoClr | input | 1 | Empty the queue and the holding slot |
| charValid | input | 1 | Receiver delivers a finished character |
| charData | input | 8 | Received byte |
| charBrk | input | 1 | Break flag for this character |
| charFrm | input | 1 | Framing error flag for this character |
| charPar | input | 1 | Parity error flag for this character |
| dataRd | input | 1 | Host reads and removes the head byte |
| lsrRd | input | 1 | Host reads the line status |
| rdData | output | 8 | Head byte (zero when empty) |
| dataReady | output | 1 | At least one character is queued |
| overrun | output | 1 | Latched overrun flag |
| parityErr | output | 1 | Head character has a parity error |
| framingErr | output | 1 | Head character has a framing error |
| breakErr | output | 1 | Head character came from a break |
| rdAvail | output | 1 | Queued count has reached the threshold |

## Verification
The assertions assume that `fifoEn` changes only while the queue and the holding slot are empty. They also assume that `fifoClr` and `lsrRd` are single-cycle pulses. Several overrun properties exclude a same-cycle `dataRd` from their premise, because a read in that cycle legally frees room. The stimulus switches mode only after the queue has been drained or cleared. It drives exactly one strobe per cycle, so every premise is met in the way the properties expect.

// File: rtl/rx_err_queue_pkg.sv
package rx_err_queue_pkg;
  localparam int DATA_W = 8;

  typedef struct packed {
    logic              brk;
    logic              frm;
    logic              par;
    logic [DATA_W-1:0] data;
  } rxEntry_t;

  typedef struct packed {
    logic push;       // write one entry at the tail
    logic fromHold;   // the pushed entry comes from the holding slot
    logic pop;        // advance the head
    logic overwrite;  // replace the head entry (single mode)
    logic loadHold;   // capture the incoming entry in the holding slot
    logic clear;      // reset the pointers
  } rxStrobe_t;
endpackage

// File: rtl/rx_err_queue_datapath.sv
module rx_err_queue_datapath
  import rx_err_queue_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic      clk,
  input  logic      rstN,
  input  rxStrobe_t stb,
  input  rxEntry_t  inEntry,
  output rxEntry_t  headEntry
);
  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);

  rxEntry_t         mem [DEPTH];
  rxEntry_t         holdEntry;
  logic [PTR_W-1:0] wrPtr, rdPtr;

  function automatic logic [PTR_W-1:0] nextPtr(input logic [PTR_W-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (!rstN || stb.clear) begin
      wrPtr <= '0;
      rdPtr <= '0;
    end else begin
      if (stb.push) wrPtr <= nextPtr(wrPtr);
      if (stb.pop)  rdPtr <= nextPtr(rdPtr);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) holdEntry <= '0;
    else if (stb.loadHold) holdEntry <= inEntry;
  end

  always_ff @(posedge clk) begin
    if (stb.push && !stb.clear)
      mem[wrPtr] <= stb.fromHold ? holdEntry : inEntry;
    else if (stb.overwrite && !stb.clear)
      mem[rdPtr] <= inEntry;
  end

  assign headEntry = mem[rdPtr];

  // R4 / R1: the control never asks for a tail write and a head overwrite at once
  a_r4_push_xor_overwrite: assert property (@(posedge clk) disable iff (!rstN)
    !(stb.push && stb.overwrite));
  // R5: a held entry is only drained in a cycle that also frees a slot
  a_r5_hold_drain_with_pop: assert property (@(posedge clk) disable iff (!rstN)
    stb.fromHold |-> stb.pop);
endmodule

// File: rtl/rx_err_queue_ctrl.sv
module rx_err_queue_ctrl
  import rx_err_queue_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             fifoEn,
  input  logic             fifoClr,
  input  logic             charValid,
  input  logic             dataRd,
  input  logic             lsrRd,
  output rxStrobe_t        stb,
  output logic [CNT_W-1:0] count,
  output logic             overrun,
  output logic             seen
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(DEPTH);

  logic holdValid, holdNext, ovrSet, popOk, headChange;

  always_comb begin
    stb      = '0;
    ovrSet   = 1'b0;
    holdNext = holdValid;
    popOk    = dataRd && (count != '0);
    stb.pop  = popOk;
    stb.clear = fifoClr;
    if (fifoClr) begin
      stb.pop  = 1'b0;
      holdNext = 1'b0;
    end else if (fifoEn) begin
      if (charValid) begin
        if (holdValid) begin
          stb.loadHold = 1'b1;
          if (popOk) begin
            stb.push     = 1'b1;
            stb.fromHold = 1'b1;
          end else begin
            ovrSet = 1'b1;
          end
        end else if (count < FULL || popOk) begin
          stb.push = 1'b1;
        end else begin
          stb.loadHold = 1'b1;
          holdNext     = 1'b1;
        end
      end else if (holdValid && popOk) begin
        stb.push     = 1'b1;
        stb.fromHold = 1'b1;
        holdNext     = 1'b0;
      end
    end else if (charValid) begin
      if (count == '0 || popOk) begin
        stb.push = 1'b1;
      end else begin
        stb.overwrite = 1'b1;
        ovrSet        = 1'b1;
      end
    end
    headChange = stb.pop || stb.overwrite || fifoClr || (stb.push && count == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      count     <= '0;
      holdValid <= 1'b0;
      overrun   <= 1'b0;
      seen      <= 1'b0;
    end else begin
      count     <= fifoClr ? '0 : count + CNT_W'(stb.push) - CNT_W'(stb.pop);
      holdValid <= holdNext;
      if (ovrSet)     overrun <= 1'b1;
      else if (lsrRd) overrun <= 1'b0;
      if (headChange) seen <= 1'b0;
      else if (lsrRd) seen <= 1'b1;
    end
  end

  // R10: the count never leaves its legal range
  a_r10_count_bound: assert property (@(posedge clk) disable iff (!rstN)
    count <= FULL);
  // R5: a character landing in an empty holding slot never raises overrun
  a_r5_full_alone_no_ovr: assert property (@(posedge clk) disable iff (!rstN)
    fifoEn && charValid && !holdValid && !overrun && !fifoClr |=> !overrun);
  // R6: a character arriving on an occupied holding slot raises overrun
  a_r6_ovr_on_busy_hold: assert property (@(posedge clk) disable iff (!rstN)
    fifoEn && charValid && holdValid && !dataRd && !fifoClr |=> overrun);
  // R4: single mode, unread character replaced
  a_r4_single_ovr: assert property (@(posedge clk) disable iff (!rstN)
    !fifoEn && charValid && count != '0 && !dataRd && !fifoClr |=> overrun);
  // R9: clearing the queue leaves the overrun flag alone
  a_r9_clear_keeps_ovr: assert property (@(posedge clk) disable iff (!rstN)
    fifoClr && !lsrRd |=> overrun == $past(overrun));
  // R7: reading the last character empties the queue
  a_r7_last_read_empties: assert property (@(posedge clk) disable iff (!rstN)
    dataRd && count == CNT_W'(1) && !charValid && !holdValid && !fifoClr |=> count == '0);
endmodule

// File: rtl/rx_err_queue.sv
module rx_err_queue
  import rx_err_queue_pkg::*;
#(
  parameter int DEPTH = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              fifoEn,
  input  logic [1:0]        trigSel,
  input  logic              fifoClr,
  input  logic              charValid,
  input  logic [DATA_W-1:0] charData,
  input  logic              charBrk,
  input  logic              charFrm,
  input  logic              charPar,
  input  logic              dataRd,
  input  logic              lsrRd,
  output logic [DATA_W-1:0] rdData,
  output logic              dataReady,
  output logic              overrun,
  output logic              parityErr,
  output logic              framingErr,
  output logic              breakErr,
  output logic              rdAvail
);
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [CNT_W-1:0] LVL0 = CNT_W'(1);
  localparam logic [CNT_W-1:0] LVL1 = CNT_W'((DEPTH / 4 > 0) ? DEPTH / 4 : 1);
  localparam logic [CNT_W-1:0] LVL2 = CNT_W'((DEPTH / 2 > 0) ? DEPTH / 2 : 1);
  localparam logic [CNT_W-1:0] LVL3 = CNT_W'((DEPTH > 2) ? DEPTH - 2 : 1);

  rxStrobe_t        stb;
  rxEntry_t         inEntry, headEntry;
  logic [CNT_W-1:0] count, trigLvl;
  logic             seen, showTags;

  assign inEntry = '{brk: charBrk, frm: charFrm, par: charPar, data: charData};

  rx_err_queue_ctrl #(.DEPTH(DEPTH), .CNT_W(CNT_W)) uCtrl (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .fifoClr(fifoClr),
    .charValid(charValid), .dataRd(dataRd), .lsrRd(lsrRd),
    .stb(stb), .count(count), .overrun(overrun), .seen(seen)
  );

  rx_err_queue_datapath #(.DEPTH(DEPTH)) uPath (
    .clk(clk), .rstN(rstN), .stb(stb), .inEntry(inEntry), .headEntry(headEntry)
  );

  always_comb begin
    case (trigSel)
      2'd0:    trigLvl = LVL0;
      2'd1:    trigLvl = LVL1;
      2'd2:    trigLvl = LVL2;
      default: trigLvl = LVL3;
    endcase
  end

  assign dataReady  = (count != '0);
  assign showTags   = dataReady && !seen;
  assign rdData     = dataReady ? headEntry.data : '0;
  assign breakErr   = showTags && headEntry.brk;
  assign framingErr = showTags && headEntry.frm;
  assign parityErr  = showTags && headEntry.par;
  assign rdAvail    = fifoEn ? (count >= trigLvl) : dataReady;

  // R3: a status read with no head movement hides the head flags
  a_r3_lsr_hides_tags: assert property (@(posedge clk) disable iff (!rstN)
    lsrRd && !dataRd && !charValid |=> !breakErr && !framingErr && !parityErr);
  // R3: a status read without a new overrun clears the flag
  a_r3_lsr_clears_ovr: assert property (@(posedge clk) disable iff (!rstN)
    lsrRd && !charValid |=> !overrun);
  // R2: no flag is reported while the queue is empty
  a_r2_no_tags_when_empty: assert property (@(posedge clk) disable iff (!rstN)
    !dataReady |-> !(breakErr || framingErr || parityErr));
endmodule

// File: tb/tb_rx_err_queue.sv
module tb_rx_err_queue;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       fifoEn = 1'b0, fifoClr = 1'b0, charValid = 1'b0, dataRd = 1'b0, lsrRd = 1'b0;
  logic [1:0] trigSel = 2'd0;
  logic [7:0] charData = '0;
  logic       charBrk = 1'b0, charFrm = 1'b0, charPar = 1'b0;
  logic [7:0] rdData;
  logic       dataReady, overrun, parityErr, framingErr, breakErr, rdAvail;

  always #2 clk = ~clk;

  rx_err_queue dut (
    .clk(clk), .rstN(rstN), .fifoEn(fifoEn), .trigSel(trigSel), .fifoClr(fifoClr),
    .charValid(charValid), .charData(charData), .charBrk(charBrk), .charFrm(charFrm),
    .charPar(charPar), .dataRd(dataRd), .lsrRd(lsrRd), .rdData(rdData),
    .dataReady(dataReady), .overrun(overrun), .parityErr(parityErr),
    .framingErr(framingErr), .breakErr(breakErr), .rdAvail(rdAvail)
  );

  int nCmp = 0, nBad = 0;
  bit done = 0;
  // scoreboard: {brk, frm, par, data}
  logic [10:0] sbQ[$];
  logic [10:0] holdE;
  bit holdV = 0, ovrM = 0, seenM = 0;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    nCmp++;
    if (got !== exp) begin
      nBad++;
      $display("FAIL %s got=%0h exp=%0h", req, got, exp);
    end
  endtask

  function automatic int trigLvl();
    case (trigSel)
      2'd0: return 1;
      2'd1: return 4;
      2'd2: return 8;
      default: return 14;
    endcase
  endfunction

  task automatic checkState(input string req);
    logic [10:0] h;
    bit avail;
    h = (sbQ.size() > 0) ? sbQ[0] : 11'd0;
    avail = fifoEn ? (sbQ.size() >= trigLvl()) : (sbQ.size() > 0);
    chk({req, " R7 dataReady"}, dataReady, sbQ.size() > 0);
    chk({req, " overrun"}, overrun, ovrM);
    chk({req, " R8 rdAvail"}, rdAvail, avail);
    chk({req, " R1 rdData"}, rdData, h[7:0]);
    chk({req, " R2 tags"}, {breakErr, framingErr, parityErr},
        (sbQ.size() > 0 && !seenM) ? h[10:8] : 3'b000);
  endtask

  task automatic sendChar(input logic [10:0] e);
    @(negedge clk);
    {charBrk, charFrm, charPar, charData} = e;
    charValid = 1'b1;
    @(negedge clk);
    charValid = 1'b0;
    if (fifoEn) begin
      if (holdV) begin ovrM = 1; holdE = e; end
      else if (sbQ.size() < 16) begin if (sbQ.size() == 0) seenM = 0; sbQ.push_back(e); end
      else begin holdV = 1; holdE = e; end
    end else begin
      if (sbQ.size() == 0) sbQ.push_back(e);
      else begin sbQ[0] = e; ovrM = 1; end
      seenM = 0;
    end
  endtask

  task automatic readData();
    @(negedge clk);
    dataRd = 1'b1;
    @(negedge clk);
    dataRd = 1'b0;
    if (sbQ.size() > 0) begin
      void'(sbQ.pop_front());
      seenM = 0;
      if (holdV) begin sbQ.push_back(holdE); holdV = 0; end
    end
  endtask

  task automatic readLsr();
    @(negedge clk);
    lsrRd = 1'b1;
    @(negedge clk);
    lsrRd = 1'b0;
    ovrM = 0;
    seenM = 1;
  endtask

  task automatic clearQ();
    @(negedge clk);
    fifoClr = 1'b1;
    @(negedge clk);
    fifoClr = 1'b0;
    sbQ.delete();
    holdV = 0;
    seenM = 0;
  endtask

  // monitor side: drains the scoreboard, comparing each head before it is removed
  task automatic drainAll(input string req);
    while (sbQ.size() > 0) begin
      checkState(req);
      readData();
    end
    checkState(req);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    checkState("R7 reset");

    // single mode: unread character replaced (R4)
    fifoEn = 1'b0;
    sendChar(11'h041);
    checkState("R4 first");
    sendChar({3'b100, 8'h42});
    checkState("R4 replaced");
    chk("R4 overrun set", overrun, 1'b1);
    chk("R4 new byte kept", rdData, 8'h42);
    readLsr();
    checkState("R3 after lsr");
    readData();
    checkState("R7 emptied");

    // queued mode with tags, threshold 4 (R1, R2, R3, R8)
    fifoEn = 1'b1;
    trigSel = 2'd1;
    sendChar({3'b001, 8'h10});
    sendChar({3'b000, 8'h11});
    sendChar({3'b010, 8'h12});
    checkState("R8 below");
    sendChar({3'b100, 8'h13});
    checkState("R8 at level");
    chk("R2 parity on head", parityErr, 1'b1);
    chk("R2 later framing hidden", framingErr, 1'b0);
    readLsr();
    checkState("R3 hidden");
    readData();
    checkState("R1 second");
    readData();
    chk("R2 framing at head", framingErr, 1'b1);
    drainAll("R1 drain");

    // empty read ignored (R10)
    readData();
    checkState("R10 empty read");
    sendChar({3'b000, 8'h5A});
    checkState("R10 intact");
    readData();

    // fill, holding slot, overrun (R5, R6, R8)
    trigSel = 2'd3;
    for (int i = 0; i < 16; i++) begin
      sendChar({3'b000, 8'h80 + 8'(i)});
      checkState("R8 fill");
    end
    sendChar({3'b010, 8'hA0});
    checkState("R5 held");
    chk("R5 no overrun", overrun, 1'b0);
    sendChar({3'b001, 8'hA1});
    checkState("R6 second");
    chk("R6 overrun", overrun, 1'b1);
    drainAll("R6 drain");

    // clear keeps overrun (R9)
    trigSel = 2'd0;
    sendChar({3'b000, 8'h01});
    sendChar({3'b000, 8'h02});
    for (int i = 0; i < 15; i++) sendChar({3'b000, 8'h20 + 8'(i)});
    sendChar({3'b000, 8'h30});
    checkState("R9 before");
    clearQ();
    checkState("R9 after clear");
    chk("R9 overrun kept", overrun, 1'b1);
    sendChar({3'b100, 8'h77});
    checkState("R9 reuse");
    readLsr();
    drainAll("R9 drain");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nCmp++;
      nBad++;
      $display("FAIL watchdog got=timeout exp=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end
endmodule